// File: doc/BRIEF.md
# Four-Stage Expiry Watchdog Timer

This block is a watchdog that software must service regularly. A small periodic timer divides the system clock down to a 1 MHz reference and produces one tick every programmed number of reference periods. Each tick lowers a watchdog countdown by one. When the countdown runs out, the block does not reset the system straight away. It reloads the countdown and moves to the next expiry stage. A system reset request is raised only when the countdown runs out for the fourth time, so the full window is four times the programmed period.

Software reaches the block through five 32-bit registers on a plain select/write bus. Reads return data combinationally. The registers are a configuration word, a status word (current count and expiry stage), a command word, an unlock key and the timer load word. A start command also serves as the keep-alive ping. An optional sticky interrupt warns software after an early expiry. A stop command takes effect only when a key write comes immediately before it.

Top module: `wdog_quad_expiry`

## Requirements
- R1: After reset, the configuration, status and timer load registers read 0, and `wdt_irq` and `sys_rst_req` are low.
- R2: The configuration register (address 0x00) holds these fields: timer select in bits [3:0], period P in bits [11:4], interrupt enable in bit 12 and reset enable in bit 15. Every other bit reads 0.
- R3: The timer load register (address 0x10) holds enable in bit 31, periodic in bit 30 and reload value R in bits [29:0]. Writing it restarts the reference phase. While the timer is enabled it ticks once every R reference periods, and one reference period is CLK_PER_REF clocks. In one-shot mode, enable clears after the first tick. Writing 0 stops the ticks.
- R4: Writing bit 0 of the command register (address 0x08) loads the count with P, sets the stage to 0, clears the interrupt flag and starts the countdown.
- R5: Each tick while running lowers the count by one. Status (address 0x04) shows the count in bits [11:4] and the stage in bits [13:12]. When the count runs out in stages 0 to 2, the count reloads to P and the stage increments.
- R6: On the fourth expiry the count reads 0, the stage reads 3 and the countdown halts. If reset enable is set, `sys_rst_req` rises and stays high until `rst_n`, even across a ping.
- R7: After t ticks from a start, (3 − stage) × P + count equals 4P − t, with a floor of 0.
- R8: When interrupt enable is set, each expiry before the fourth sets a sticky `wdt_irq`, and a start clears it. When interrupt enable is clear, `wdt_irq` never rises.
- R9: Writing 0x0000C45A to the unlock register (address 0x0C), then command bit 1 on the next command write, stops the countdown and freezes the count. A stop wins over a tick in the same cycle.
- R10: Every command write consumes the unlock. A stop with no unlock, a stop after an intervening command write, or a stop after a wrong key has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdt_irq | output | 1 | Sticky early-expiry interrupt |
| sys_rst_req | output | 1 | Held system reset request |

## Verification
The bench builds the block with CLK_PER_REF = 2, so a reference period lasts two clocks and a tick arrives every 2R clocks. At that scale, a sweep can walk every tick of the whole four-stage window for periods from 1 up to the maximum of 255, and for two reload values. After every tick the bench checks the status fields, the remaining-time identity, the interrupt and the reset request. Directed sequences at known tick phases cover one-shot and stopped timers, a ping mid-window, and the unlock rules, including a stop that lands on the same edge as a tick.

// File: rtl/wdq_pkg.sv
package wdq_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned CNT_W      = 8;
  localparam int unsigned STG_W      = 2;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned PER_LSB    = 4;
  localparam int unsigned IRQ_EN_BIT = 12;
  localparam int unsigned RST_EN_BIT = 15;
  localparam int unsigned STG_LSB    = 12;
  localparam int unsigned TMR_EN_BIT = 31;
  localparam int unsigned TMR_PER_BIT = 30;

  localparam logic [ADDR_W-1:0] OFS_CFG = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STS = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_KEY = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_TMR = 5'h10;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h0000_C45A;

  typedef struct packed {
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] period;
    logic [SEL_W-1:0] tsel;
  } cfg_t;
endpackage

// File: rtl/wdq_tick_gen.sv
module wdq_tick_gen
  import wdq_pkg::*;
#(
  parameter int unsigned CLK_PER_REF = 125,
  parameter int unsigned RELOAD_W    = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [BUS_W-1:0] load_data,
  output logic             tick_o,
  output logic [BUS_W-1:0] load_rd
);
  localparam int unsigned PRE_W = (CLK_PER_REF > 1) ? $clog2(CLK_PER_REF) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_REF - 1);
  localparam logic [RELOAD_W-1:0] ONE = RELOAD_W'(1);

  logic [PRE_W-1:0]    pre_q, pre_d;
  logic                en_q, en_d;
  logic                per_q, per_d;
  logic [RELOAD_W-1:0] rld_q, rld_d;
  logic [RELOAD_W-1:0] cnt_q, cnt_d;
  logic                ref_pulse;
  logic                wrap;

  assign ref_pulse = (pre_q == PRE_LAST);
  assign wrap      = en_q && ref_pulse && (cnt_q <= ONE);
  assign tick_o    = wrap;

  always_comb begin
    pre_d = pre_q;
    en_d  = en_q;
    per_d = per_q;
    rld_d = rld_q;
    cnt_d = cnt_q;
    if (load_we || ref_pulse) pre_d = '0;
    else                      pre_d = pre_q + PRE_W'(1);
    if (load_we) begin
      en_d  = load_data[TMR_EN_BIT];
      per_d = load_data[TMR_PER_BIT];
      rld_d = load_data[RELOAD_W-1:0];
      cnt_d = load_data[RELOAD_W-1:0];
    end else if (en_q && ref_pulse) begin
      if (cnt_q <= ONE) begin
        cnt_d = rld_q;
        if (!per_q) en_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      en_q  <= 1'b0;
      per_q <= 1'b0;
      rld_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      en_q  <= en_d;
      per_q <= per_d;
      rld_q <= rld_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    load_rd                 = '0;
    load_rd[TMR_EN_BIT]     = en_q;
    load_rd[TMR_PER_BIT]    = per_q;
    load_rd[RELOAD_W-1:0]   = rld_q;
  end
endmodule

// File: rtl/wdq_countdown.sv
module wdq_countdown
  import wdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] period,
  input  logic             irq_en,
  input  logic             rst_en,
  output logic [CNT_W-1:0] count,
  output logic [STG_W-1:0] stage,
  output logic             running,
  output logic             irq,
  output logic             rst_req
);
  localparam logic [STG_W-1:0] STG_LAST = {STG_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [STG_W-1:0] stg_q, stg_d;
  logic             run_q, run_d;
  logic             irq_q, irq_d;
  logic             rst_q, rst_d;
  logic             expire;

  assign expire = run_q && tick && (cnt_q <= ONE);

  always_comb begin
    cnt_d = cnt_q;
    stg_d = stg_q;
    run_d = run_q;
    irq_d = irq_q;
    rst_d = rst_q;
    if (stop) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d = 1'b1;
      cnt_d = period;
      stg_d = '0;
      irq_d = 1'b0;
    end else if (expire) begin
      if (stg_q == STG_LAST) begin
        cnt_d = '0;
        run_d = 1'b0;
        if (rst_en) rst_d = 1'b1;
      end else begin
        cnt_d = period;
        stg_d = stg_q + STG_W'(1);
        if (irq_en) irq_d = 1'b1;
      end
    end else if (run_q && tick) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stg_q <= '0;
      run_q <= 1'b0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stg_q <= stg_d;
      run_q <= run_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  assign count   = cnt_q;
  assign stage   = stg_q;
  assign running = run_q;
  assign irq     = irq_q;
  assign rst_req = rst_q;
endmodule

// File: rtl/wdq_regs.sv
module wdq_regs
  import wdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  sts_count,
  input  logic [STG_W-1:0]  sts_stage,
  input  logic [BUS_W-1:0]  tmr_rd,
  output cfg_t              cfg,
  output logic              tmr_we,
  output logic              cmd_wr,
  output logic              start,
  output logic              stop,
  output logic              unlocked,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic wr;
  logic cfg_we, key_we;
  cfg_t cfg_q, cfg_d;
  logic unl_q, unl_d;

  assign wr     = bus_sel && bus_write;
  assign cfg_we = wr && (bus_addr == OFS_CFG);
  assign key_we = wr && (bus_addr == OFS_KEY);
  assign cmd_wr = wr && (bus_addr == OFS_CMD);
  assign tmr_we = wr && (bus_addr == OFS_TMR);
  assign start  = cmd_wr && bus_wdata[0];
  assign stop   = cmd_wr && bus_wdata[1] && unl_q;

  always_comb begin
    cfg_d.tsel   = bus_wdata[SEL_W-1:0];
    cfg_d.period = bus_wdata[PER_LSB +: CNT_W];
    cfg_d.irq_en = bus_wdata[IRQ_EN_BIT];
    cfg_d.rst_en = bus_wdata[RST_EN_BIT];
  end

  always_comb begin
    unl_d = unl_q;
    if (key_we)      unl_d = (bus_wdata == UNLOCK_KEY);
    else if (cmd_wr) unl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unl_q <= 1'b0;
    else        unl_q <= unl_d;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CFG: begin
        bus_rdata[SEL_W-1:0]         = cfg_q.tsel;
        bus_rdata[PER_LSB +: CNT_W]  = cfg_q.period;
        bus_rdata[IRQ_EN_BIT]        = cfg_q.irq_en;
        bus_rdata[RST_EN_BIT]        = cfg_q.rst_en;
      end
      OFS_STS: begin
        bus_rdata[PER_LSB +: CNT_W]  = sts_count;
        bus_rdata[STG_LSB +: STG_W]  = sts_stage;
      end
      OFS_TMR: bus_rdata = tmr_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign cfg      = cfg_q;
  assign unlocked = unl_q;
endmodule

// File: rtl/wdog_quad_expiry.sv
module wdog_quad_expiry
  import wdq_pkg::*;
#(
  parameter int unsigned CLK_PER_REF = 125,
  parameter int unsigned RELOAD_W    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              wdt_irq,
  output logic              sys_rst_req
);
  cfg_t             cfg;
  logic             tmr_we;
  logic             rg_cmd_wr, rg_start, rg_stop, rg_unlock;
  logic [BUS_W-1:0] tmr_rd;
  logic             wd_tick;
  logic [CNT_W-1:0] cd_count;
  logic [STG_W-1:0] cd_stage;
  logic             cd_run;

  wdq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sts_count (cd_count),
    .sts_stage (cd_stage),
    .tmr_rd    (tmr_rd),
    .cfg       (cfg),
    .tmr_we    (tmr_we),
    .cmd_wr    (rg_cmd_wr),
    .start     (rg_start),
    .stop      (rg_stop),
    .unlocked  (rg_unlock),
    .bus_rdata (bus_rdata)
  );

  wdq_tick_gen #(
    .CLK_PER_REF (CLK_PER_REF),
    .RELOAD_W    (RELOAD_W)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (tmr_we),
    .load_data (bus_wdata),
    .tick_o    (wd_tick),
    .load_rd   (tmr_rd)
  );

  wdq_countdown u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (wd_tick),
    .start   (rg_start),
    .stop    (rg_stop),
    .period  (cfg.period),
    .irq_en  (cfg.irq_en),
    .rst_en  (cfg.rst_en),
    .count   (cd_count),
    .stage   (cd_stage),
    .running (cd_run),
    .irq     (wdt_irq),
    .rst_req (sys_rst_req)
  );
endmodule

// File: rtl/wdq_checker.sv
module wdq_checker
  import wdq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_req,
  input logic             wdt_irq,
  input logic [CNT_W-1:0] cd_count,
  input logic [STG_W-1:0] cd_stage,
  input logic             cd_run,
  input logic             wd_tick,
  input logic             rg_cmd_wr,
  input logic             rg_start,
  input logic             rg_stop,
  input logic             rg_unlock,
  input logic [1:0]       cmd_bits
);
  localparam logic [STG_W-1:0] STG_LAST = {STG_W{1'b1}};

  p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);

  p_rst_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> (cd_stage == STG_LAST) && (cd_count == '0) && !cd_run);

  p_dec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_run && wd_tick && !rg_start && !rg_stop && (cd_count > CNT_W'(1)))
    |=> (cd_count == $past(cd_count) - CNT_W'(1)));

  p_stage_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cd_stage) |-> (cd_stage == '0) || (cd_stage == $past(cd_stage) + STG_W'(1)));

  p_ping_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_start && !rg_stop) |=> (!wdt_irq && (cd_stage == '0) && cd_run));

  p_stop_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rg_stop |=> !cd_run);

  p_locked_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_cmd_wr && cmd_bits == 2'b10 && !rg_unlock && cd_run && !wd_tick) |=> cd_run);

  p_unlock_used_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rg_cmd_wr |=> !rg_unlock);
endmodule

bind wdog_quad_expiry wdq_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sys_rst_req (sys_rst_req),
  .wdt_irq     (wdt_irq),
  .cd_count    (cd_count),
  .cd_stage    (cd_stage),
  .cd_run      (cd_run),
  .wd_tick     (wd_tick),
  .rg_cmd_wr   (rg_cmd_wr),
  .rg_start    (rg_start),
  .rg_stop     (rg_stop),
  .rg_unlock   (rg_unlock),
  .cmd_bits    (bus_wdata[1:0])
);

// File: tb/wdog_quad_expiry_tb.sv
`timescale 1ns/1ps
module wdog_quad_expiry_tb;
  localparam int DIV = 2;
  localparam logic [4:0] A_CFG = 5'h00, A_STS = 5'h04, A_CMD = 5'h08,
                         A_KEY = 5'h0C, A_TMR = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_write;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wdt_irq, sys_rst_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_quad_expiry #(.CLK_PER_REF(DIV), .RELOAD_W(30)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_irq(wdt_irq), .sys_rst_req(sys_rst_req));

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic read_sts(output int cnt, output int stg);
    logic [31:0] v;
    rd(A_STS, v);
    cnt = int'(v[11:4]);
    stg = int'(v[13:12]);
  endtask

  task automatic sweep(input int p, input int r, input bit ie, input bit re);
    int cnt, stg, ec, es;
    do_reset();
    wr(A_CFG, (32'(re) << 15) | (32'(ie) << 12) | (32'(p) << 4) | 32'h5);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'hC000_0000 | 32'(r));
    for (int k = 0; k <= 4 * p + 1; k++) begin
      if (k > 0) repeat (r * DIV) @(negedge clk);
      if (k >= 4 * p) begin ec = 0; es = 3; end
      else begin es = k / p; ec = p - (k % p); end
      read_sts(cnt, stg);
      chk("R5 count", cnt, ec);
      chk("R5 stage", stg, es);
      chk("R7 remaining", (3 - stg) * p + cnt, (k >= 4 * p) ? 0 : 4 * p - k);
      chk("R8 irq", wdt_irq, (ie && k >= p) ? 1 : 0);
      chk("R6 rst_req", sys_rst_req, (re && k >= 4 * p) ? 1 : 0);
    end
    wr(A_CMD, 32'h1);
    read_sts(cnt, stg);
    chk("R4 ping reload", cnt, p);
    chk("R4 ping stage", stg, 0);
    chk("R6 rst held after ping", sys_rst_req, re ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt, stg;

    // R1: reset state
    do_reset();
    rd(A_CFG, v); chk("R1 cfg", v, 0);
    rd(A_STS, v); chk("R1 sts", v, 0);
    rd(A_TMR, v); chk("R1 tmr", v, 0);
    chk("R1 irq", wdt_irq, 0);
    chk("R1 rst_req", sys_rst_req, 0);

    // R2: field layout
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, v); chk("R2 cfg all ones", v, 32'h0000_9FFF);
    wr(A_CFG, 32'h0000_1A53);
    rd(A_CFG, v); chk("R2 cfg pattern", v, 32'h0000_1A53);

    // R3: timer readback, one-shot, stop
    do_reset();
    wr(A_TMR, 32'hC000_0003);
    rd(A_TMR, v); chk("R3 tmr readback", v, 32'hC000_0003);
    wr(A_CFG, 32'h0000_0030);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'h8000_0002);
    repeat (2 * DIV) @(negedge clk);
    read_sts(cnt, stg); chk("R3 one-shot first tick", cnt, 2);
    rd(A_TMR, v); chk("R3 one-shot enable cleared", v, 32'h0000_0002);
    repeat (12) @(negedge clk);
    read_sts(cnt, stg); chk("R3 one-shot no more ticks", cnt, 2);
    wr(A_TMR, 32'hC000_0001);
    repeat (2) @(negedge clk);
    read_sts(cnt, stg); chk("R3 periodic tick", cnt, 1);
    wr(A_TMR, 32'h0);
    repeat (10) @(negedge clk);
    read_sts(cnt, stg); chk("R3 zero load stops", cnt, 1);
    chk("R3 zero load stage", stg, 0);

    // R4/R8: ping mid-window
    do_reset();
    wr(A_CFG, 32'h0000_1020);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'hC000_0001);
    repeat (4) @(negedge clk);
    read_sts(cnt, stg);
    chk("R5 first expiry stage", stg, 1);
    chk("R5 first expiry reload", cnt, 2);
    chk("R8 irq set", wdt_irq, 1);
    wr(A_CMD, 32'h1);
    read_sts(cnt, stg);
    chk("R4 ping count", cnt, 2);
    chk("R4 ping stage", stg, 0);
    chk("R8 irq cleared by ping", wdt_irq, 0);
    @(negedge clk);
    read_sts(cnt, stg); chk("R4 counting after ping", cnt, 1);

    // R9/R10: unlock rules
    do_reset();
    wr(A_CFG, 32'h0000_0050);
    wr(A_CMD, 32'h1);
    wr(A_TMR, 32'hC000_0001);
    wr(A_CMD, 32'h2);
    @(negedge clk);
    read_sts(cnt, stg); chk("R10 stop without key ignored", cnt, 4);
    wr(A_KEY, 32'h0000_C45A);
    wr(A_CMD, 32'h2);
    read_sts(cnt, stg); chk("R9 stop wins over tick", cnt, 4);
    repeat (6) @(negedge clk);
    read_sts(cnt, stg); chk("R9 count frozen", cnt, 4);
    wr(A_CMD, 32'h1);
    read_sts(cnt, stg); chk("R4 restart after stop", cnt, 5);
    wr(A_KEY, 32'h0000_C45A);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    repeat (2) @(negedge clk);
    read_sts(cnt, stg); chk("R10 key consumed by ping", cnt, 3);
    wr(A_KEY, 32'h0000_C45B);
    wr(A_CMD, 32'h2);
    repeat (2) @(negedge clk);
    read_sts(cnt, stg); chk("R10 wrong key ignored", cnt, 1);

    // R5/R6/R7/R8: full-window sweeps
    sweep(1, 1, 1'b1, 1'b1);
    sweep(2, 3, 1'b0, 1'b1);
    sweep(3, 1, 1'b1, 1'b0);
    sweep(7, 3, 1'b1, 1'b1);
    sweep(255, 1, 1'b0, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule